// File: doc/BRIEF.md
# Banked CPU Register File

This block is the architectural register storage of a small 16-bit processor core. It keeps four 16-bit data registers (D0 to D3), two address registers (A0, A1) and a frame base register (FB), each present in two copies that form two banks. Alongside them sit registers that exist only once: a user stack pointer, an interrupt stack pointer, a static base, a 20-bit program counter, a 20-bit interrupt vector table base and a 16-bit flag word. Instruction decode, the ALU and interrupt sequencing are outside the block. They reach the registers only through two combinational read ports and one synchronous write port.

Each port names a register with a 4-bit code and picks an access size. D0 and D1 can be reached as 8-bit halves. D0 and D1 can also be joined with D2 and D3 into 32-bit pairs. Bit 4 of the flag word picks the bank that every banked access uses. Bit 7 picks which stack pointer the "active stack pointer" code reaches. The ports carry register accesses rather than a data stream, so they are plain pins with no valid/ready handshake and no back-pressure. A write is accepted in every cycle in which `wr_en` is high. Each read port returns data in the same cycle as its request.

Top module: `banked_regfile`

## Requirements
- R1: Register codes are 0..3 D0..D3, 4 A0, 5 A1, 6 FB, 7 USP, 8 ISP, 9 SB, 10 active stack pointer, 11 flags, 12 PC, 13 vector base low, 14 vector base high, and 15 unused. Size codes are 0 byte, 1 word, 2 pair, and 3 acts as word. A word write to a 16-bit register stores `wr_data[15:0]`. A word read returns that register zero-extended to 32 bits. Code 15 reads zero, and writes to it are dropped.
- R2: A byte access is allowed on D0 and D1 only. `hi`=1 selects bits 15:8 and `hi`=0 selects bits 7:0. A byte write stores `wr_data[7:0]` into the chosen half and leaves the other half unchanged. A byte read returns the chosen half zero-extended.
- R3: A pair access with code 0 reaches {D2,D0}, and with code 1 it reaches {D3,D1}. The upper register sits on bits 31:16. A pair write updates both registers.
- R4: Flag bit 4 picks the bank, and every access to codes 0..6 uses the selected bank. A write to one bank leaves the other bank unchanged.
- R5: A write that changes flag bit 4 takes effect on the next cycle. In the cycle of the flag write, reads still use the old bank.
- R6: Code 10 reads and writes USP when flag bit 7 is 0, and ISP when flag bit 7 is 1.
- R7: The flag bits are carry at bit 0, debug at 1, zero at 2, sign at 3, bank at 4, overflow at 5, interrupt enable at 6, stack select at 7, and the 3-bit interrupt priority level at bits 14:12. All other bits read 0, and writes to them are dropped. `flg_o` always shows the flag word.
- R8: PC is 20 bits wide. A write stores `wr_data[19:0]`, and a read returns PC zero-extended.
- R9: The vector base is 20 bits wide. Code 13 reaches bits 15:0. Code 14 reaches bits 19:16: a write takes `wr_data[3:0]` and a read returns those 4 bits zero-extended.
- R10: While `rst` is high at a clock edge, every register in both banks and every unbanked register is cleared. This selects bank 0 and USP.
- R11: The two read ports are independent and combinational. A write becomes visible on the read ports in the cycle after its clock edge.
- R12: A byte write to any code other than 0 and 1 is dropped. A pair access to any code other than 0 and 1 acts as a word access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_sel | input | NRD x 4 | Register code for each read port |
| rd_size | input | NRD x 2 | Access size for each read port |
| rd_hi | input | NRD | High-half select for byte reads, one bit per port |
| rd_data | output | NRD x 32 | Read data for each port |
| wr_en | input | 1 | Write enable |
| wr_sel | input | 4 | Register code for the write |
| wr_size | input | 2 | Access size for the write |
| wr_hi | input | 1 | High-half select for byte writes |
| wr_data | input | 32 | Write data |
| flg_o | output | 16 | Current flag word |

## Verification
The assertions check the following on every cycle: a byte write keeps the other half of its register, a write to one bank keeps the other bank, the stack pointer that the select flag does not pick keeps its value, the flag word after a write holds only the defined bits, and reset clears the flags. The bench's reference model compares both read ports on every cycle. Its scenarios show the rest: pair assembly, bank switching with a one-cycle delay, same-cycle reads returning old data, the split vector base and the dropped accesses.

// File: rtl/brf_pkg.sv
package brf_pkg;
  typedef enum logic [3:0] {
    SEL_D0 = 4'd0, SEL_D1 = 4'd1, SEL_D2 = 4'd2, SEL_D3 = 4'd3,
    SEL_A0 = 4'd4, SEL_A1 = 4'd5, SEL_FB = 4'd6, SEL_USP = 4'd7,
    SEL_ISP = 4'd8, SEL_SB = 4'd9, SEL_SP = 4'd10, SEL_FLG = 4'd11,
    SEL_PC = 4'd12, SEL_ITL = 4'd13, SEL_ITH = 4'd14, SEL_NONE = 4'd15
  } rsel_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0, SZ_WORD = 2'd1, SZ_PAIR = 2'd2, SZ_ALT = 2'd3
  } rsize_e;

  localparam logic [15:0] FLG_MASK = 16'h70FF;
  localparam int FLG_BANK = 4;
  localparam int FLG_USEL = 7;
  localparam int NBANKED  = 7;
endpackage

// File: rtl/brf_bank_store.sv
module brf_bank_store #(
  parameter int DW    = 16,
  parameter int NBANK = 2,
  parameter int NREG  = 7
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [BW-1:0]            wr_bank,
  input  logic [IW-1:0]            wr_idx,
  input  logic [1:0]               wr_bmask,
  input  logic [DW-1:0]            wr_word,
  input  logic                     wr_pair,
  input  logic [DW-1:0]            wr_upper,
  input  logic [BW-1:0]            rd_bank,
  output logic [NREG-1:0][DW-1:0]  act_regs
);
  localparam int BW = (NBANK > 1) ? $clog2(NBANK) : 1;
  localparam int IW = $clog2(NREG);
  localparam int HB = DW / 2;

  logic [DW-1:0] mem [NBANK][NREG];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    for (genvar i = 0; i < NREG; i++) begin : g_reg
      logic hit, hit_up;
      assign hit = wr_en && (wr_bank == BW'(b)) && (wr_idx == IW'(i));
      if (i >= 2) begin : g_up
        assign hit_up = wr_en && wr_pair && (wr_bank == BW'(b)) && (wr_idx == IW'(i - 2));
      end else begin : g_noup
        assign hit_up = 1'b0;
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          mem[b][i] <= '0;
        end else if (hit_up) begin
          mem[b][i] <= wr_upper;
        end else if (hit) begin
          if (wr_bmask[0]) mem[b][i][HB-1:0]  <= wr_word[HB-1:0];
          if (wr_bmask[1]) mem[b][i][DW-1:HB] <= wr_word[DW-1:HB];
        end
      end

      // R2: a low-half write keeps the high half, and a high-half write keeps the low half
      p_half_keep_hi_r2: assert property (@(posedge clk) disable iff (rst)
        (hit && wr_bmask == 2'b01) |=> $stable(mem[b][i][DW-1:HB]));
      p_half_keep_lo_r2: assert property (@(posedge clk) disable iff (rst)
        (hit && wr_bmask == 2'b10) |=> $stable(mem[b][i][HB-1:0]));
      // R4: a write aimed at another bank leaves this copy alone
      p_bank_iso_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_bank != BW'(b)) |=> $stable(mem[b][i]));
    end
  end

  always_comb begin
    for (int i = 0; i < NREG; i++) act_regs[i] = mem[rd_bank][i];
  end
endmodule

// File: rtl/brf_ctrl_regs.sv
module brf_ctrl_regs
  import brf_pkg::*;
#(
  parameter int DW  = 16,
  parameter int PCW = 20
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  rsel_e          sel,
  input  logic [PCW-1:0] wdata,
  output logic [DW-1:0]  usp,
  output logic [DW-1:0]  isp,
  output logic [DW-1:0]  sb,
  output logic [PCW-1:0] pc,
  output logic [PCW-1:0] itb,
  output logic [DW-1:0]  flg
);
  localparam int XW = PCW - DW;

  always_ff @(posedge clk) begin
    if (rst) begin
      usp <= '0;
      isp <= '0;
      sb  <= '0;
      pc  <= '0;
      itb <= '0;
      flg <= '0;
    end else if (we) begin
      case (sel)
        SEL_USP: usp <= wdata[DW-1:0];
        SEL_ISP: isp <= wdata[DW-1:0];
        SEL_SB:  sb  <= wdata[DW-1:0];
        SEL_SP: begin
          if (flg[FLG_USEL]) isp <= wdata[DW-1:0];
          else               usp <= wdata[DW-1:0];
        end
        SEL_FLG: flg <= wdata[DW-1:0] & FLG_MASK;
        SEL_PC:  pc  <= wdata;
        SEL_ITL: itb[DW-1:0]  <= wdata[DW-1:0];
        SEL_ITH: itb[PCW-1:DW] <= wdata[XW-1:0];
        default: ;
      endcase
    end
  end

  // R6: with the user pointer selected, the interrupt pointer keeps its value
  p_stk_keep_isp_r6: assert property (@(posedge clk) disable iff (rst)
    (we && sel == SEL_SP && !flg[FLG_USEL]) |=> $stable(isp));
  p_stk_keep_usp_r6: assert property (@(posedge clk) disable iff (rst)
    (we && sel == SEL_SP && flg[FLG_USEL]) |=> $stable(usp));
  // R7: after a flag write only the defined bits survive
  p_flg_write_r7: assert property (@(posedge clk) disable iff (rst)
    (we && sel == SEL_FLG) |=> (flg == ($past(wdata[DW-1:0]) & FLG_MASK)));
  // R9: writing the high part of the vector base keeps the low part
  p_itb_split_r9: assert property (@(posedge clk) disable iff (rst)
    (we && sel == SEL_ITH) |=> $stable(itb[DW-1:0]));
endmodule

// File: rtl/brf_read_mux.sv
module brf_read_mux
  import brf_pkg::*;
#(
  parameter int DW   = 16,
  parameter int PCW  = 20,
  parameter int NREG = 7
) (
  input  logic [NREG-1:0][DW-1:0] act_regs,
  input  logic [DW-1:0]           usp,
  input  logic [DW-1:0]           isp,
  input  logic [DW-1:0]           sb,
  input  logic [PCW-1:0]          pc,
  input  logic [PCW-1:0]          itb,
  input  logic [DW-1:0]           flg,
  input  logic [3:0]              sel,
  input  logic [1:0]              size,
  input  logic                    hi,
  output logic [2*DW-1:0]         data
);
  localparam int HB = DW / 2;
  localparam int XW = PCW - DW;

  rsel_e  s;
  rsize_e z;

  always_comb begin
    s = rsel_e'(sel);
    z = rsize_e'(size);
    data = '0;
    case (s)
      SEL_D0, SEL_D1: begin
        if (z == SZ_BYTE)
          data = {{(2*DW-HB){1'b0}}, hi ? act_regs[sel[0]][DW-1:HB] : act_regs[sel[0]][HB-1:0]};
        else if (z == SZ_PAIR)
          data = {act_regs[{2'b01, sel[0]}], act_regs[sel[0]]};
        else
          data = {{DW{1'b0}}, act_regs[sel[0]]};
      end
      SEL_D2, SEL_D3, SEL_A0, SEL_A1, SEL_FB:
        data = {{DW{1'b0}}, act_regs[sel[2:0]]};
      SEL_USP: data = {{DW{1'b0}}, usp};
      SEL_ISP: data = {{DW{1'b0}}, isp};
      SEL_SB:  data = {{DW{1'b0}}, sb};
      SEL_SP:  data = {{DW{1'b0}}, flg[FLG_USEL] ? isp : usp};
      SEL_FLG: data = {{DW{1'b0}}, flg};
      SEL_PC:  data = {{(2*DW-PCW){1'b0}}, pc};
      SEL_ITL: data = {{DW{1'b0}}, itb[DW-1:0]};
      SEL_ITH: data = {{(2*DW-XW){1'b0}}, itb[PCW-1:DW]};
      default: data = '0;
    endcase
  end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import brf_pkg::*;
#(
  parameter int DW    = 16,
  parameter int PCW   = 20,
  parameter int NRD   = 2,
  parameter int NBANK = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NRD-1:0][3:0]       rd_sel,
  input  logic [NRD-1:0][1:0]       rd_size,
  input  logic [NRD-1:0]            rd_hi,
  output logic [NRD-1:0][2*DW-1:0]  rd_data,
  input  logic                      wr_en,
  input  logic [3:0]                wr_sel,
  input  logic [1:0]                wr_size,
  input  logic                      wr_hi,
  input  logic [2*DW-1:0]           wr_data,
  output logic [DW-1:0]             flg_o
);
  localparam int HB = DW / 2;

  rsel_e  wsel;
  rsize_e wsz;
  logic   is_banked, byte_ok, st_en, st_pair, ctl_we;
  logic [1:0]    st_bmask;
  logic [DW-1:0] st_word;

  logic [NBANKED-1:0][DW-1:0] act_regs;
  logic [DW-1:0]  usp, isp, sb, flg;
  logic [PCW-1:0] pc, itb;

  always_comb begin
    wsel      = rsel_e'(wr_sel);
    wsz       = rsize_e'(wr_size);
    is_banked = (wsel <= SEL_FB);
    byte_ok   = (wsel == SEL_D0) || (wsel == SEL_D1);
    st_en     = wr_en && is_banked && !(wsz == SZ_BYTE && !byte_ok);
    st_bmask  = (wsz == SZ_BYTE) ? (wr_hi ? 2'b10 : 2'b01) : 2'b11;
    st_word   = (wsz == SZ_BYTE) ? {wr_data[HB-1:0], wr_data[HB-1:0]} : wr_data[DW-1:0];
    st_pair   = (wsz == SZ_PAIR) && byte_ok;
    ctl_we    = wr_en && !is_banked && (wsz != SZ_BYTE);
  end

  brf_bank_store #(.DW(DW), .NBANK(NBANK), .NREG(NBANKED)) u_store (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (st_en),
    .wr_bank  (flg[FLG_BANK]),
    .wr_idx   (wr_sel[2:0]),
    .wr_bmask (st_bmask),
    .wr_word  (st_word),
    .wr_pair  (st_pair),
    .wr_upper (wr_data[2*DW-1:DW]),
    .rd_bank  (flg[FLG_BANK]),
    .act_regs (act_regs)
  );

  brf_ctrl_regs #(.DW(DW), .PCW(PCW)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .we    (ctl_we),
    .sel   (wsel),
    .wdata (wr_data[PCW-1:0]),
    .usp   (usp),
    .isp   (isp),
    .sb    (sb),
    .pc    (pc),
    .itb   (itb),
    .flg   (flg)
  );

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    brf_read_mux #(.DW(DW), .PCW(PCW), .NREG(NBANKED)) u_mux (
      .act_regs (act_regs),
      .usp      (usp),
      .isp      (isp),
      .sb       (sb),
      .pc       (pc),
      .itb      (itb),
      .flg      (flg),
      .sel      (rd_sel[p]),
      .size     (rd_size[p]),
      .hi       (rd_hi[p]),
      .data     (rd_data[p])
    );

    // R7: reading the flag word never shows a reserved bit
    p_flg_read_r7: assert property (@(posedge clk) disable iff (rst)
      (rd_sel[p] == SEL_FLG) |-> ((rd_data[p] & ~{{DW{1'b0}}, FLG_MASK}) == '0));
  end

  assign flg_o = flg;

  // R10: reset leaves bank 0 and the user stack pointer selected
  p_rst_clear_r10: assert property (@(posedge clk) rst |=> (flg_o == '0));
  // R5: a flag write sets the bank bit that is used from the next cycle on
  p_bank_next_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == SEL_FLG && wr_size != SZ_BYTE) |=> (flg_o[FLG_BANK] == $past(wr_data[FLG_BANK])));
  // R12: a byte write outside D0/D1 never changes the flag word
  p_byte_drop_r12: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_size == SZ_BYTE) |=> $stable(flg_o));
endmodule

// File: tb/banked_regfile_bench.sv
module banked_regfile_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0][3:0]  rd_sel;
  logic [1:0][1:0]  rd_size;
  logic [1:0]       rd_hi;
  logic [1:0][31:0] rd_data;
  logic        wr_en;
  logic [3:0]  wr_sel;
  logic [1:0]  wr_size;
  logic        wr_hi;
  logic [31:0] wr_data;
  logic [15:0] flg_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  banked_regfile u_banked_regfile (
    .clk(clk), .rst(rst), .rd_sel(rd_sel), .rd_size(rd_size), .rd_hi(rd_hi),
    .rd_data(rd_data), .wr_en(wr_en), .wr_sel(wr_sel), .wr_size(wr_size),
    .wr_hi(wr_hi), .wr_data(wr_data), .flg_o(flg_o)
  );

  // behavioural reference state
  logic [15:0] md [2][4];
  logic [15:0] ma [2][3];
  logic [15:0] musp, misp, msb, mflg;
  logic [19:0] mpc, mitb;

  task automatic mclear();
    for (int b = 0; b < 2; b++) begin
      for (int i = 0; i < 4; i++) md[b][i] = 16'h0;
      for (int i = 0; i < 3; i++) ma[b][i] = 16'h0;
    end
    musp = 0; misp = 0; msb = 0; mflg = 0; mpc = 0; mitb = 0;
  endtask

  function automatic logic [31:0] mread(int sel, int size, bit hi);
    int b = int'(mflg[4]);
    if (sel < 4) begin
      if (size == 0 && sel < 2) return hi ? {24'h0, md[b][sel][15:8]} : {24'h0, md[b][sel][7:0]};
      if (size == 2 && sel < 2) return {md[b][sel+2], md[b][sel]};
      return {16'h0, md[b][sel]};
    end
    case (sel)
      4, 5, 6: return {16'h0, ma[b][sel-4]};
      7:  return {16'h0, musp};
      8:  return {16'h0, misp};
      9:  return {16'h0, msb};
      10: return {16'h0, mflg[7] ? misp : musp};
      11: return {16'h0, mflg};
      12: return {12'h0, mpc};
      13: return {16'h0, mitb[15:0]};
      14: return {28'h0, mitb[19:16]};
      default: return 32'h0;
    endcase
  endfunction

  task automatic mwrite(int sel, int size, bit hi, logic [31:0] d);
    int b = int'(mflg[4]);
    if (sel < 4) begin
      if (size == 0) begin
        if (sel < 2) begin
          if (hi) md[b][sel][15:8] = d[7:0];
          else    md[b][sel][7:0]  = d[7:0];
        end
      end else if (size == 2 && sel < 2) begin
        md[b][sel] = d[15:0];
        md[b][sel+2] = d[31:16];
      end else md[b][sel] = d[15:0];
    end else if (size != 0) begin
      case (sel)
        4, 5, 6: ma[b][sel-4] = d[15:0];
        7:  musp = d[15:0];
        8:  misp = d[15:0];
        9:  msb  = d[15:0];
        10: if (mflg[7]) misp = d[15:0]; else musp = d[15:0];
        11: mflg = d[15:0] & 16'h70FF;
        12: mpc = d[19:0];
        13: mitb[15:0] = d[15:0];
        14: mitb[19:16] = d[3:0];
        default: ;
      endcase
    end
  endtask

  function automatic string rtag(int sel, int size);
    if (sel < 2 && size == 0) return "R2";
    if (sel < 2 && size == 2) return "R3";
    if (sel == 10) return "R6";
    if (sel == 11) return "R7";
    if (sel == 12) return "R8";
    if (sel == 13 || sel == 14) return "R9";
    if (sel >= 4 && sel <= 6) return "R4";
    return "R1";
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: inputs already driven after a falling edge; compare, clock, update model
  task automatic cyc();
    #1;
    for (int p = 0; p < 2; p++)
      chk(rtag(int'(rd_sel[p]), int'(rd_size[p])), rd_data[p],
          mread(int'(rd_sel[p]), int'(rd_size[p]), rd_hi[p]));
    chk("R7", {16'h0, flg_o}, {16'h0, mflg});
    @(posedge clk);
    if (rst) mclear();
    else if (wr_en) mwrite(int'(wr_sel), int'(wr_size), wr_hi, wr_data);
    @(negedge clk);
  endtask

  task automatic wr(int sel, int size, bit hi, logic [31:0] d);
    wr_en = 1; wr_sel = 4'(sel); wr_size = 2'(size); wr_hi = hi; wr_data = d;
    cyc();
    wr_en = 0;
  endtask

  task automatic peek(int sel, int size, bit hi, logic [31:0] exp, string tag);
    rd_sel[0] = 4'(sel); rd_size[0] = 2'(size); rd_hi[0] = hi;
    #1;
    chk(tag, rd_data[0], exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr = 32'hACE1_2468;
    mclear();
    wr_en = 0; wr_sel = 0; wr_size = 1; wr_hi = 0; wr_data = 0;
    rd_sel = '0; rd_size = {2'd1, 2'd1}; rd_hi = '0;
    @(negedge clk);
    repeat (3) cyc();
    rst = 0;
    // R10: everything cleared, bank 0, user pointer selected
    peek(11, 1, 0, 32'h0, "R10");
    peek(0, 2, 0, 32'h0, "R10");
    wr(10, 1, 0, 32'h1234);
    peek(7, 1, 0, 32'h1234, "R10");
    peek(8, 1, 0, 32'h0, "R10");
    // R1 word access
    wr(0, 1, 0, 32'hFFFF_A1B2);
    peek(0, 1, 0, 32'h0000_A1B2, "R1");
    // R2 byte halves
    wr(0, 0, 1, 32'h0000_00CC);
    peek(0, 1, 0, 32'h0000_CCB2, "R2");
    peek(0, 0, 1, 32'h0000_00CC, "R2");
    peek(0, 0, 0, 32'h0000_00B2, "R2");
    wr(1, 0, 0, 32'h0000_0055);
    peek(1, 1, 0, 32'h0000_0055, "R2");
    // R3 pairs
    wr(0, 2, 0, 32'h1122_3344);
    peek(0, 1, 0, 32'h0000_3344, "R3");
    peek(2, 1, 0, 32'h0000_1122, "R3");
    wr(3, 1, 0, 32'h0000_7777);
    peek(1, 2, 0, 32'h7777_0055, "R3");
    // R11 same-cycle read shows old data, next cycle new
    rd_sel[1] = 4'd0; rd_size[1] = 2'd1; rd_hi[1] = 0;
    wr_en = 1; wr_sel = 0; wr_size = 1; wr_hi = 0; wr_data = 32'hBEEF;
    #1 chk("R11", rd_data[1], 32'h3344);
    cyc(); wr_en = 0;
    #1 chk("R11", rd_data[1], 32'hBEEF);
    // R4 / R5 banking
    wr_en = 1; wr_sel = 11; wr_size = 1; wr_data = 32'h0010;
    #1 chk("R5", rd_data[1], 32'hBEEF);
    cyc(); wr_en = 0;
    #1 chk("R5", rd_data[1], 32'h0);
    wr(0, 1, 0, 32'h5A5A);
    wr(4, 1, 0, 32'h0A0A);
    wr(11, 1, 0, 32'h0);
    peek(0, 1, 0, 32'hBEEF, "R4");
    peek(4, 1, 0, 32'h0, "R4");
    wr(11, 1, 0, 32'h0010);
    peek(0, 1, 0, 32'h5A5A, "R4");
    wr(11, 1, 0, 32'h0);
    // R6 stack select
    wr(11, 1, 0, 32'h0080);
    wr(10, 1, 0, 32'h4321);
    peek(8, 1, 0, 32'h4321, "R6");
    peek(7, 1, 0, 32'h1234, "R6");
    peek(10, 1, 0, 32'h4321, "R6");
    // R7 reserved bits
    wr(11, 1, 0, 32'hFFFF_FFFF);
    peek(11, 1, 0, 32'h0000_70FF, "R7");
    wr(11, 1, 0, 32'h0);
    // R8 program counter
    wr(12, 1, 0, 32'hFABC_DE12);
    peek(12, 1, 0, 32'h000C_DE12, "R8");
    // R9 vector base halves
    wr(13, 1, 0, 32'h0000_9876);
    wr(14, 1, 0, 32'h000F_FFF5);
    peek(13, 1, 0, 32'h9876, "R9");
    peek(14, 1, 0, 32'h5, "R9");
    // R12 dropped byte writes, pair acting as word
    wr(4, 1, 0, 32'h1111);
    wr(4, 0, 0, 32'h22);
    peek(4, 1, 0, 32'h1111, "R12");
    wr(9, 0, 0, 32'h33);
    peek(9, 1, 0, 32'h0, "R12");
    wr(4, 2, 0, 32'hDEAD_0001);
    peek(4, 1, 0, 32'h0001, "R12");
    peek(6, 1, 0, 32'h0, "R12");
    peek(2, 1, 0, 32'h1122, "R12");
    wr(15, 1, 0, 32'hFFFF);
    peek(15, 1, 0, 32'h0, "R1");
    // randomized traffic compared against the model every cycle
    for (int n = 0; n < 4000; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      rd_sel[0] = lfsr[3:0]; rd_size[0] = lfsr[5:4]; rd_hi[0] = lfsr[6];
      rd_sel[1] = lfsr[10:7]; rd_size[1] = lfsr[12:11]; rd_hi[1] = lfsr[13];
      wr_en = lfsr[14]; wr_sel = lfsr[18:15]; wr_size = lfsr[20:19]; wr_hi = lfsr[21];
      wr_data = {lfsr[15:0], lfsr[31:16]} ^ 32'h5A5A_C3C3;
      rst = (lfsr[31:23] == 9'h1FF);
      cyc();
    end
    rst = 0; wr_en = 0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule